// File: doc/BRIEF.md
# Per-Cache Coherence Agent

This block sits between a processor and the interconnect of a directory-based shared-memory system. It keeps a coherence state for every line of a small direct-mapped cache: invalid, shared, modified, or pending. Loads and stores that the cache can serve finish locally. Any other access becomes a request for a readable copy or a writable exclusive copy, sent to the home directory. The line then waits in the pending state until the home's data reply installs it.

The agent also serves requests that the home starts. An invalidate drops a copy. A writeback demand returns dirty data and keeps a readable copy. A flush demand returns the data and drops the line. Every outgoing message carries the agent's site number, which is a module parameter. The interconnect is assumed to be lossless and to keep the order of messages between any two endpoints.

Top module: `coh_cache_agent`

## Requirements
- R1: After reset every line is invalid, no message or response is valid, and `cpu_req_ready` is high.
- R2: A load to a line held shared or modified, or a store to a line held modified, raises `cpu_resp_valid` in the cycle after acceptance and sends no message. A load returns the stored word. A store writes the word.
- R3: A load that misses sends a shared-copy request (type 0) for the word address in the next cycle, and the line becomes pending. A matching shared reply (type 8) installs the line as shared and returns the reply data on `cpu_rdata`.
- R4: A store that misses, or a store to a line held shared, sends an exclusive request (type 1) and the line becomes pending. A matching exclusive reply (type 9) installs the line as modified, holding the store word, and completes the store.
- R5: While a miss is pending, `cpu_req_ready` stays low. A shared or exclusive reply whose address differs from the pending address is ignored: there is no response and the miss stays pending.
- R6: An invalidate demand (type 3) is answered in the next cycle by an invalidate acknowledge (type 6) with zero data. A matching shared or modified copy becomes invalid.
- R7: A writeback demand (type 2) to a line held modified returns a writeback reply (type 5) carrying the word, and the line becomes shared.
- R8: A flush demand (type 4) to a line held modified returns a flush reply (type 7) carrying the word, and the line becomes invalid.
- R9: A writeback or flush demand for an address that is not held modified still receives its reply type, with zero data, and no line changes.
- R10: A miss whose line slot holds a different address in the modified state first sends a flush reply (type 7) with the old address and word. The request for the new address follows in the next cycle in which no incoming message is present.
- R11: Each outgoing message has a type of 0, 1, 5, 6 or 7, and `out_site` equals the site parameter. Line index = address bits [IDX_W-1:0].
- R12: A processor request is not accepted in a cycle in which `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present (accepted when ready) |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store word |
| cpu_req_ready | output | 1 | Request accepted this cycle if valid |
| cpu_resp_valid | output | 1 | Access completed |
| cpu_rdata | output | DATA_W | Line word after the access |
| in_valid | input | 1 | Incoming message present |
| in_type | input | 4 | Incoming message type |
| in_addr | input | ADDR_W | Incoming message address |
| in_data | input | DATA_W | Incoming message data |
| out_valid | output | 1 | Outgoing message present |
| out_type | output | 4 | Outgoing message type |
| out_addr | output | ADDR_W | Outgoing message address |
| out_data | output | DATA_W | Outgoing message data |
| out_site | output | SITE_W | Sender site number |

## Verification
The bench builds the agent with four lines, an 8-bit word address and site number 5. This keeps two tags that share a slot (0x05 and 0x09) close together, so a victim eviction is easy to reach. The stimulus covers the shared-to-modified upgrade, home demands that arrive in the same cycle as a processor request, stale demands for addresses the agent has already given up, and replies with the wrong address during a pending miss. A behavioural model predicts the ready flag, the outgoing message and the processor response for every cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [3:0] {
    M_SH_REQ    = 4'd0,
    M_EX_REQ    = 4'd1,
    M_WB_DEM    = 4'd2,
    M_INV_DEM   = 4'd3,
    M_FLUSH_DEM = 4'd4,
    M_WB_RSP    = 4'd5,
    M_INV_ACK   = 4'd6,
    M_FLUSH_RSP = 4'd7,
    M_SH_GRANT  = 4'd8,
    M_EX_GRANT  = 4'd9
  } msg_e;

  typedef enum logic [1:0] {
    LN_INV  = 2'd0,
    LN_SHR  = 2'd1,
    LN_MOD  = 2'd2,
    LN_PEND = 2'd3
  } line_e;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output line_e             a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_e             b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              w_en,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_e             w_state,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic              w_data_en,
  input  logic [DATA_W-1:0] w_data
);
  line_e             st_q  [NUM_LINES];
  logic [TAG_W-1:0]  tag_q [NUM_LINES];
  logic [DATA_W-1:0] mem_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]  <= LN_INV;
        tag_q[g] <= '0;
      end else if (w_en && w_idx == IDX_W'(g)) begin
        st_q[g]  <= w_state;
        tag_q[g] <= w_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (w_data_en) mem_q[w_idx] <= w_data;
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = mem_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = mem_q[b_idx];

  // R4: data is only written together with a state update
  assert_data_with_state_R4: assert property (@(posedge clk) disable iff (rst)
    w_data_en |-> w_en);
endmodule

// File: rtl/coh_miss_tracker.sv
module coh_miss_tracker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_write,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              start_defer,
  input  logic              sent,
  input  logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              write,
  output logic [DATA_W-1:0] wdata,
  output logic              send_due
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      send_due <= 1'b0;
      addr     <= '0;
      write    <= 1'b0;
      wdata    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      send_due <= start_defer;
      addr     <= start_addr;
      write    <= start_write;
      wdata    <= start_wdata;
    end else begin
      if (done) busy <= 1'b0;
      if (sent) send_due <= 1'b0;
    end
  end

  assert_single_miss_R5: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  assert_no_early_done_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> busy && !send_due);
endmodule

// File: rtl/coh_cache_agent.sv
module coh_cache_agent
  import coh_pkg::*;
#(
  parameter int SITE_ID   = 1,
  parameter int SITE_W    = 4,
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              in_valid,
  input  logic [3:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [3:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [SITE_W-1:0] out_site
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_e             a_state, b_state, w_state;
  logic [TAG_W-1:0]  a_tag, b_tag, w_tag;
  logic [DATA_W-1:0] a_data, b_data, w_data;
  logic              w_en, w_data_en;
  logic [IDX_W-1:0]  w_idx;

  logic              t_busy, t_write, t_send_due;
  logic [ADDR_W-1:0] t_addr;
  logic [DATA_W-1:0] t_wdata;
  logic              t_start, t_defer, t_sent, t_done;

  logic [IDX_W-1:0]  c_idx, i_idx;
  logic [TAG_W-1:0]  c_tag, i_tag;
  assign c_idx = cpu_req_addr[IDX_W-1:0];
  assign c_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign i_idx = in_addr[IDX_W-1:0];
  assign i_tag = in_addr[ADDR_W-1:IDX_W];

  coh_line_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk, .rst,
    .a_idx(c_idx), .a_state, .a_tag, .a_data,
    .b_idx(i_idx), .b_state, .b_tag, .b_data,
    .w_en, .w_idx, .w_state, .w_tag, .w_data_en, .w_data
  );

  coh_miss_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_miss (
    .clk, .rst,
    .start(t_start), .start_addr(cpu_req_addr), .start_write(cpu_req_write),
    .start_wdata(cpu_req_wdata), .start_defer(t_defer),
    .sent(t_sent), .done(t_done),
    .busy(t_busy), .addr(t_addr), .write(t_write), .wdata(t_wdata),
    .send_due(t_send_due)
  );

  logic accept, a_match, b_match, ld_hit, st_hit, hit, victim_dirty, reply_match;
  assign cpu_req_ready = !t_busy && !in_valid;
  assign accept       = cpu_req_valid && cpu_req_ready;
  assign a_match      = (a_tag == c_tag);
  assign b_match      = (b_tag == i_tag);
  assign ld_hit       = !cpu_req_write && a_match && (a_state == LN_SHR || a_state == LN_MOD);
  assign st_hit       = cpu_req_write && a_match && (a_state == LN_MOD);
  assign hit          = ld_hit || st_hit;
  assign victim_dirty = (a_state == LN_MOD) && !a_match;
  assign reply_match  = in_valid && (in_type == M_SH_GRANT || in_type == M_EX_GRANT) &&
                        t_busy && !t_send_due && (in_addr == t_addr);

  logic              n_out_v, n_resp_v;
  logic [3:0]        n_type;
  logic [ADDR_W-1:0] n_addr;
  logic [DATA_W-1:0] n_data, n_rdata;

  always_comb begin
    w_en = 1'b0; w_idx = c_idx; w_state = LN_INV; w_tag = c_tag;
    w_data_en = 1'b0; w_data = cpu_req_wdata;
    n_out_v = 1'b0; n_type = M_SH_REQ; n_addr = in_addr; n_data = '0;
    n_resp_v = 1'b0; n_rdata = '0;
    t_start = 1'b0; t_defer = 1'b0; t_sent = 1'b0; t_done = 1'b0;
    if (in_valid) begin
      w_idx = i_idx;
      w_tag = b_tag;
      unique case (in_type)
        M_SH_GRANT, M_EX_GRANT: if (reply_match) begin
          w_en      = 1'b1;
          w_tag     = i_tag;
          w_state   = (in_type == M_EX_GRANT) ? LN_MOD : LN_SHR;
          w_data_en = 1'b1;
          w_data    = t_write ? t_wdata : in_data;
          n_resp_v  = 1'b1;
          n_rdata   = t_write ? t_wdata : in_data;
          t_done    = 1'b1;
        end
        M_INV_DEM: begin
          n_out_v = 1'b1; n_type = M_INV_ACK;
          if (b_match && (b_state == LN_SHR || b_state == LN_MOD)) begin
            w_en = 1'b1; w_state = LN_INV;
          end
        end
        M_WB_DEM: begin
          n_out_v = 1'b1; n_type = M_WB_RSP;
          if (b_match && b_state == LN_MOD) begin
            n_data = b_data; w_en = 1'b1; w_state = LN_SHR;
          end
        end
        M_FLUSH_DEM: begin
          n_out_v = 1'b1; n_type = M_FLUSH_RSP;
          if (b_match && b_state == LN_MOD) begin
            n_data = b_data; w_en = 1'b1; w_state = LN_INV;
          end
        end
        default: ;
      endcase
    end else if (accept) begin
      if (hit) begin
        n_resp_v = 1'b1;
        n_rdata  = cpu_req_write ? cpu_req_wdata : a_data;
        if (cpu_req_write) begin
          w_en = 1'b1; w_state = LN_MOD; w_data_en = 1'b1;
        end
      end else begin
        w_en    = 1'b1;
        w_state = LN_PEND;
        t_start = 1'b1;
        n_out_v = 1'b1;
        if (victim_dirty) begin
          t_defer = 1'b1;
          n_type  = M_FLUSH_RSP;
          n_addr  = {a_tag, c_idx};
          n_data  = a_data;
        end else begin
          n_type = cpu_req_write ? M_EX_REQ : M_SH_REQ;
          n_addr = cpu_req_addr;
        end
      end
    end else if (t_send_due) begin
      t_sent  = 1'b1;
      n_out_v = 1'b1;
      n_type  = t_write ? M_EX_REQ : M_SH_REQ;
      n_addr  = t_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_type       <= '0;
      out_addr       <= '0;
      out_data       <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_rdata      <= '0;
    end else begin
      out_valid      <= n_out_v;
      out_type       <= n_type;
      out_addr       <= n_addr;
      out_data       <= n_data;
      cpu_resp_valid <= n_resp_v;
      cpu_rdata      <= n_rdata;
    end
  end

  assign out_site = SITE_W'(SITE_ID);

  assert_hit_local_R2: assert property (@(posedge clk) disable iff (rst)
    accept && hit |=> cpu_resp_valid && !out_valid);
  assert_miss_sends_R3: assert property (@(posedge clk) disable iff (rst)
    accept && !hit |=> out_valid && !cpu_resp_valid);
  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    t_busy && !reply_match |=> t_busy);
  assert_inv_ack_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_type == M_INV_DEM |=> out_valid && out_type == M_INV_ACK);
  assert_out_legal_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_type == M_SH_REQ || out_type == M_EX_REQ || out_type == M_WB_RSP ||
                   out_type == M_INV_ACK || out_type == M_FLUSH_RSP));
endmodule

// File: tb/coh_cache_agent_bench.sv
module coh_cache_agent_bench;
  localparam int SITE = 5;
  localparam int SH_REQ = 0, EX_REQ = 1, WB_DEM = 2, INV_DEM = 3, FL_DEM = 4;
  localparam int WB_RSP = 5, INV_ACK = 6, FL_RSP = 7, SH_GR = 8, EX_GR = 9;
  localparam int ST_I = 0, ST_S = 1, ST_M = 2, ST_P = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cv = 0, cw = 0, iv = 0;
  logic [7:0] ca = 0, ia = 0;
  logic [31:0] cd = 0, id = 0;
  logic [3:0] it = 0;
  logic ready, resp_v, out_v;
  logic [31:0] rdata, out_d;
  logic [3:0] out_t;
  logic [7:0] out_a;
  logic [3:0] out_s;

  always #2 clk = ~clk;

  coh_cache_agent #(.SITE_ID(SITE), .SITE_W(4), .NUM_LINES(4), .ADDR_W(8), .DATA_W(32)) u_coh_cache_agent (
    .clk, .rst, .cpu_req_valid(cv), .cpu_req_write(cw), .cpu_req_addr(ca), .cpu_req_wdata(cd),
    .cpu_req_ready(ready), .cpu_resp_valid(resp_v), .cpu_rdata(rdata),
    .in_valid(iv), .in_type(it), .in_addr(ia), .in_data(id),
    .out_valid(out_v), .out_type(out_t), .out_addr(out_a), .out_data(out_d), .out_site(out_s));

  int n_chk = 0, n_err = 0, cycles = 0;
  int m_st[4], m_tag[4];
  logic [31:0] m_dat[4];
  bit m_pend, m_pwr, m_due;
  logic [7:0] m_pa;
  logic [31:0] m_pwd;
  bit e_ov, e_rv;
  int e_t;
  logic [7:0] e_a;
  logic [31:0] e_d, e_rd;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin m_st[k] = ST_I; m_tag[k] = 0; m_dat[k] = 0; end
    m_pend = 0; m_pwr = 0; m_due = 0; m_pa = 0; m_pwd = 0;
  endtask

  task automatic model_step();
    int x, t;
    e_ov = 0; e_rv = 0; e_t = 0; e_a = 0; e_d = 0; e_rd = 0;
    if (iv) begin
      x = ia[1:0]; t = ia[7:2];
      if ((it == SH_GR || it == EX_GR) && m_pend && !m_due && ia == m_pa) begin
        m_st[x] = (it == EX_GR) ? ST_M : ST_S; m_tag[x] = t;
        m_dat[x] = m_pwr ? m_pwd : id;
        e_rv = 1; e_rd = m_dat[x]; m_pend = 0;
      end else if (it == INV_DEM) begin
        e_ov = 1; e_t = INV_ACK; e_a = ia;
        if (m_tag[x] == t && (m_st[x] == ST_S || m_st[x] == ST_M)) m_st[x] = ST_I;
      end else if (it == WB_DEM || it == FL_DEM) begin
        e_ov = 1; e_t = (it == WB_DEM) ? WB_RSP : FL_RSP; e_a = ia;
        if (m_tag[x] == t && m_st[x] == ST_M) begin
          e_d = m_dat[x]; m_st[x] = (it == WB_DEM) ? ST_S : ST_I;
        end
      end
    end else if (cv && !m_pend) begin
      x = ca[1:0]; t = ca[7:2];
      if (m_tag[x] == t && ((!cw && (m_st[x] == ST_S || m_st[x] == ST_M)) || (cw && m_st[x] == ST_M))) begin
        e_rv = 1;
        if (cw) m_dat[x] = cd;
        e_rd = m_dat[x];
      end else begin
        e_ov = 1;
        if (m_st[x] == ST_M && m_tag[x] != t) begin
          e_t = FL_RSP; e_a = {m_tag[x][5:0], ca[1:0]}; e_d = m_dat[x]; m_due = 1;
        end else begin
          e_t = cw ? EX_REQ : SH_REQ; e_a = ca;
        end
        m_st[x] = ST_P; m_tag[x] = t; m_pend = 1; m_pa = ca; m_pwr = cw; m_pwd = cd;
      end
    end else if (m_due) begin
      m_due = 0; e_ov = 1; e_t = m_pwr ? EX_REQ : SH_REQ; e_a = m_pa;
    end
  endtask

  task automatic cyc(input bit c_v, input bit c_w, input logic [7:0] c_a, input logic [31:0] c_d,
                     input bit i_v, input int i_t, input logic [7:0] i_a, input logic [31:0] i_d,
                     input string rq);
    bit e_rdy;
    cv = c_v; cw = c_w; ca = c_a; cd = c_d; iv = i_v; it = 4'(i_t); ia = i_a; id = i_d;
    #1;
    e_rdy = !m_pend && !i_v;
    chk(ready == e_rdy, (i_v && c_v) ? "R12" : rq, "ready", ready, e_rdy);
    model_step();
    @(posedge clk); @(negedge clk);
    chk(out_v == e_ov, rq, "out_valid", out_v, e_ov);
    if (e_ov) begin
      chk(out_t == 4'(e_t), rq, "out_type", out_t, e_t);
      chk(out_a == e_a, rq, "out_addr", out_a, e_a);
      chk(out_d == e_d, rq, "out_data", out_d, e_d);
      chk(out_s == 4'(SITE), "R11", "out_site", out_s, SITE);
    end
    chk(resp_v == e_rv, rq, "resp_valid", resp_v, e_rv);
    if (e_rv) chk(rdata == e_rd, rq, "rdata", rdata, e_rd);
  endtask

  task automatic idle(input string rq);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic ld(input logic [7:0] a, input string rq);
    cyc(1, 0, a, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic st(input logic [7:0] a, input logic [31:0] d, input string rq);
    cyc(1, 1, a, d, 0, 0, 0, 0, rq);
  endtask
  task automatic msg(input int t, input logic [7:0] a, input logic [31:0] d, input string rq);
    cyc(0, 0, 0, 0, 1, t, a, d, rq);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_err++; n_chk++;
      $display("FAIL R5 watchdog cycles=%0d expected below %0d", cycles, 5000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
    chk(out_v == 1'b0, "R1", "out_valid after reset", out_v, 0);
    chk(resp_v == 1'b0, "R1", "resp after reset", resp_v, 0);
    @(negedge clk);
    // R1, R3: every slot misses after reset
    ld(8'h10, "R3");
    idle("R5");
    ld(8'h10, "R5");                      // stalled, not accepted
    msg(SH_GR, 8'h20, 32'hDEAD0000, "R5"); // wrong address ignored
    msg(SH_GR, 8'h10, 32'hAAAA1111, "R3");
    ld(8'h10, "R2");
    // R4: upgrade from shared
    st(8'h10, 32'hBBBB2222, "R4");
    idle("R5");
    msg(EX_GR, 8'h10, 32'h12345678, "R4");
    ld(8'h10, "R2");
    st(8'h10, 32'hCCCC3333, "R2");
    ld(8'h10, "R2");
    // R7
    msg(WB_DEM, 8'h10, 0, "R7");
    ld(8'h10, "R7");
    st(8'h10, 32'h0000FFFF, "R7");        // shared again: needs exclusive request
    msg(EX_GR, 8'h10, 0, "R4");
    // R12 and R6: demand collides with a load
    cyc(1, 0, 8'h10, 0, 1, INV_DEM, 8'h10, 0, "R6");
    ld(8'h10, "R6");
    msg(SH_GR, 8'h10, 32'hD0D0D0D0, "R3");
    // R8 / R9
    st(8'h21, 32'h21212121, "R4");
    msg(EX_GR, 8'h21, 32'h99999999, "R4");
    msg(FL_DEM, 8'h21, 0, "R8");
    ld(8'h21, "R8");
    msg(FL_DEM, 8'h21, 0, "R9");          // pending now, not modified
    msg(WB_DEM, 8'h33, 0, "R9");
    msg(INV_DEM, 8'h77, 0, "R9");
    msg(SH_GR, 8'h21, 32'h45454545, "R3");
    ld(8'h21, "R2");
    // R10: modified victim evicted before the new request
    st(8'h05, 32'hEEEE0005, "R4");
    msg(EX_GR, 8'h05, 0, "R4");
    st(8'h09, 32'hFFFF0009, "R10");
    msg(INV_DEM, 8'h30, 0, "R10");        // defers the queued request
    idle("R10");
    msg(EX_GR, 8'h09, 0, "R10");
    ld(8'h09, "R2");
    ld(8'h05, "R10");                     // victim gone: load misses
    idle("R5");
    msg(SH_GR, 8'h05, 32'h50505050, "R3");
    ld(8'h0C, "R3");
    msg(SH_GR, 8'h0C, 32'h0C0C0C0C, "R3");
    idle("R2");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule